// File: doc/BRIEF.md
# SPI Serial Boot Loader Sequencer

This block brings a system up from an external SPI memory after reset. It drives the SPI pins itself in mode 0: the clock idles low, data out changes while the clock is low, and data in is sampled on each rising clock. It selects the memory and sends a read command with an all-zero address. It then watches the returning bit stream for a synchronisation byte. That byte is a zero upper nibble that follows a high bit. The high bit is the pulled-up idle level for the very first byte. The lower nibble of the accepted byte selects a new shift clock divider. The read command is not repeated after the change.

After synchronisation the sequencer takes in three things in order. First comes a 16-bit boot length. Next comes a fixed block of configuration longwords. Last come the optional boot longwords, which go into on-chip SRAM through a one-cycle write strobe. The divider chosen after a power-on reset is kept in a register that only the power-on reset clears. After a later soft reset, that stored value sets the clock rate from the very first command bit.

Top module: `spi_boot_seq`

## Requirements
- R1: After reset the sequencer drives spi_cs_n low and sends 8'h03 followed by ADDR_BITS zero bits, MSB first, in mode 0. During every later clock of the transfer spi_mosi stays 0.
- R2: While no divider is stored, spi_sck toggles every 16 clk cycles (code 15). For a code c, the toggle interval is c+1 cycles, so the full period is 2*(c+1) cycles.
- R3: A received byte is accepted as the sync byte only when bits [7:4] are 0000 and the bit received just before it was 1. For the first byte, that earlier bit is the pulled-up idle level. Each rejected byte is dropped whole, and the next byte is tested.
- R4: On a power-on boot, spi_sck stops low once the sync byte is accepted. The sync byte's bits [3:0] then go into div_code and div_valid is set. spi_sck restarts at the new rate while spi_cs_n stays low.
- R5: pullup_en is 1 from reset until the sync byte is accepted, and 0 after that.
- R6: div_code and div_valid are cleared only by por_n and keep their values through rst_n. When a divider is stored, the command already runs at that rate. The sync byte is still consumed, but there is no pause and its code has no effect.
- R7: The 16 bits after the sync byte, MSB first, appear on bll.
- R8: CFG_WORDS big-endian longwords follow the length. Longword k appears at cfg_data[32k +: 32], and cfg_valid rises once all of them are in.
- R9: When bll is nonzero, bll+1 big-endian longwords follow. Each one gives a one-cycle sram_we with sram_addr counting up from 0. When bll is zero, no write occurs.
- R10: Boot longwords with index SRAM_WORDS or higher are still read from the memory, but no write is issued for them.
- R11: On the falling spi_sck after the last bit, spi_cs_n goes high, spi_sck stays low, and done pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on/hard reset, asynchronous active low; clears everything |
| rst_n | input | 1 | Soft reset, asynchronous active low; keeps the stored divider |
| spi_sck | output | 1 | Shift clock, idles low |
| spi_cs_n | output | 1 | Memory select, active low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |
| pullup_en | output | 1 | Weak pull-up request for spi_miso |
| div_code | output | 4 | Stored divider code |
| div_valid | output | 1 | Stored divider code is in use |
| bll | output | 16 | Received boot length |
| cfg_data | output | 32*CFG_WORDS | Configuration longwords |
| cfg_valid | output | 1 | Configuration complete |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | clog2(SRAM_WORDS) | SRAM longword address |
| sram_wdata | output | 32 | SRAM write data |
| done | output | 1 | One-cycle end-of-load pulse |

## Verification
The bench places rejected bytes ahead of the sync byte. One case is a byte with a zero upper nibble that follows a low bit. A design that tests only the nibble would lock one byte too early, and every later field would then be misaligned. Boots run with random divider codes and random lengths, including zero, and the bench measures the clock's half period before and after the retune. A design that skipped the pause, or that wrongly reloaded the divider on a soft reset, would show the wrong interval. A length longer than the SRAM exposes a design that wraps the address or ends the read early, and the bench also checks that done is a single cycle after the final bit.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_SYNC,
    ST_HOLD,
    ST_RETUNE,
    ST_LEN,
    ST_CFG,
    ST_BOOT,
    ST_FINISH,
    ST_DONE
  } seq_state_t;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] SAFE_CODE = 4'hF;

  // Lock rule: a zero upper nibble that is preceded by a high bit.
  function automatic logic sync_hit(input logic prev_bit, input logic [7:0] b);
    return prev_bit && (b[7:4] == 4'b0000);
  endfunction

endpackage

// File: rtl/spi_boot_rstsync.sv
module spi_boot_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign srst_n = s1_q;
endmodule

// File: rtl/spi_boot_sclk.sv
module spi_boot_sclk #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              sck,
  output logic              rise_stb,
  output logic              fall_stb
);
  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic              sck_q, sck_d;
  logic              tick;

  assign tick = run && (cnt_q == code);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck      = sck_q;
  assign rise_stb = tick && !sck_q;
  assign fall_stb = tick && sck_q;

  // R11: a stopped clock sits low
  a_r11_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_q);
  // R2: the clock moves only at the end of a counted interval
  a_r2_toggle_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(sck_q));
endmodule

// File: rtl/spi_boot_divreg.sv
module spi_boot_divreg #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              valid_q, valid_d;

  always_comb begin
    code_d  = code_q;
    valid_d = valid_q;
    if (wr_en && !valid_q) begin
      code_d  = wr_code;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      valid_q <= valid_d;
    end
  end

  assign code  = code_q;
  assign valid = valid_q;

  // R6: once stored, the divider never changes until power-on reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!por_n)
    valid_q |=> valid_q && $stable(code_q));
endmodule

// File: rtl/spi_boot_seq.sv
module spi_boot_seq
  import spi_boot_pkg::*;
#(
  parameter int unsigned CFG_WORDS  = 4,
  parameter int unsigned SRAM_WORDS = 8192,
  parameter int unsigned ADDR_BITS  = 24,
  parameter logic [7:0]  READ_CMD   = 8'h03,
  localparam int unsigned SRAM_AW   = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1,
  localparam int unsigned CFG_W     = 32 * CFG_WORDS
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  output logic               spi_sck,
  output logic               spi_cs_n,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               pullup_en,
  output logic [CODE_W-1:0]  div_code,
  output logic               div_valid,
  output logic [15:0]        bll,
  output logic [CFG_W-1:0]   cfg_data,
  output logic               cfg_valid,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [31:0]        sram_wdata,
  output logic               done
);
  localparam int unsigned CMD_BITS = 8 + ADDR_BITS;
  localparam int unsigned BCNT_W   = $clog2(CMD_BITS > 32 ? CMD_BITS : 32);
  localparam int unsigned WCNT_W   = 17;

  logic seq_arst_n, seq_rst_n, por_rst_n;
  assign seq_arst_n = rst_n & por_n;

  spi_boot_rstsync u_seq_rs (.clk(clk), .arst_n(seq_arst_n), .srst_n(seq_rst_n));
  spi_boot_rstsync u_por_rs (.clk(clk), .arst_n(por_n),      .srst_n(por_rst_n));

  seq_state_t          state_q, state_d;
  logic [BCNT_W-1:0]   bcnt_q, bcnt_d;
  logic [WCNT_W-1:0]   wcnt_q, wcnt_d;
  logic [31:0]         sr_q, sr_d;
  logic [CMD_BITS-1:0] tx_q, tx_d;
  logic                prev_q, prev_d;
  logic [CODE_W-1:0]   hold_q, hold_d;
  logic                pull_q, pull_d;
  logic [15:0]         bll_q, bll_d;
  logic                cfgv_q, cfgv_d;
  logic                we_q, we_d;
  logic [SRAM_AW-1:0]  addr_q, addr_d;
  logic [31:0]         wdata_q, wdata_d;
  logic                done_q, done_d;
  logic                csn_q, csn_d;
  logic                mosi_q, mosi_d;
  logic                div_wr, cfg_wr;
  logic                run, rise_stb, fall_stb, sck;
  logic [CODE_W-1:0]   clk_code;
  logic [31:0]         word_in;
  logic [CFG_W-1:0]    cfg_q;

  spi_boot_divreg #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .por_n(por_rst_n), .wr_en(div_wr), .wr_code(hold_q),
    .code(div_code), .valid(div_valid)
  );

  assign clk_code = div_valid ? div_code : SAFE_CODE;
  assign run = (state_q != ST_IDLE) && (state_q != ST_RETUNE) && (state_q != ST_DONE);

  spi_boot_sclk #(.CODE_W(CODE_W)) u_sclk (
    .clk(clk), .rst_n(seq_rst_n), .run(run), .code(clk_code),
    .sck(sck), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  assign word_in = {sr_q[30:0], spi_miso};

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    wcnt_d  = wcnt_q;
    sr_d    = sr_q;
    tx_d    = tx_q;
    prev_d  = prev_q;
    hold_d  = hold_q;
    pull_d  = pull_q;
    bll_d   = bll_q;
    cfgv_d  = cfgv_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    done_d  = 1'b0;
    div_wr  = 1'b0;
    cfg_wr  = 1'b0;
    if (rise_stb) sr_d = word_in;
    unique case (state_q)
      ST_IDLE: begin
        tx_d    = {READ_CMD, {ADDR_BITS{1'b0}}};
        bcnt_d  = '0;
        state_d = ST_CMD;
      end
      ST_CMD: begin
        if (fall_stb) tx_d = tx_q << 1;
        if (rise_stb) begin
          if (bcnt_q == BCNT_W'(CMD_BITS - 1)) begin
            bcnt_d  = '0;
            state_d = ST_SYNC;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        if (rise_stb) begin
          if (bcnt_q == BCNT_W'(7)) begin
            bcnt_d = '0;
            prev_d = spi_miso;
            if (sync_hit(prev_q, word_in[7:0])) begin
              pull_d  = 1'b0;
              hold_d  = word_in[3:0];
              state_d = div_valid ? ST_LEN : ST_HOLD;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (fall_stb) state_d = ST_RETUNE;
      end
      ST_RETUNE: begin
        div_wr  = 1'b1;
        state_d = ST_LEN;
      end
      ST_LEN: begin
        if (rise_stb) begin
          if (bcnt_q == BCNT_W'(15)) begin
            bcnt_d  = '0;
            wcnt_d  = '0;
            bll_d   = word_in[15:0];
            state_d = ST_CFG;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_CFG: begin
        if (rise_stb) begin
          if (bcnt_q == BCNT_W'(31)) begin
            bcnt_d = '0;
            cfg_wr = 1'b1;
            if (wcnt_q == WCNT_W'(CFG_WORDS - 1)) begin
              cfgv_d  = 1'b1;
              wcnt_d  = '0;
              state_d = (bll_q == 16'd0) ? ST_FINISH : ST_BOOT;
            end else begin
              wcnt_d = wcnt_q + 1'b1;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_BOOT: begin
        if (rise_stb) begin
          if (bcnt_q == BCNT_W'(31)) begin
            bcnt_d = '0;
            if (wcnt_q < WCNT_W'(SRAM_WORDS)) begin
              we_d    = 1'b1;
              addr_d  = wcnt_q[SRAM_AW-1:0];
              wdata_d = word_in;
            end
            if (wcnt_q == {1'b0, bll_q}) state_d = ST_FINISH;
            else                          wcnt_d  = wcnt_q + 1'b1;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_FINISH: begin
        if (fall_stb) begin
          done_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_DONE;
    endcase
    csn_d  = (state_d == ST_IDLE) || (state_d == ST_DONE);
    mosi_d = (state_d == ST_CMD) && tx_d[CMD_BITS-1];
  end

  always_ff @(posedge clk or negedge seq_rst_n) begin
    if (!seq_rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      wcnt_q  <= '0;
      sr_q    <= '0;
      tx_q    <= '0;
      prev_q  <= 1'b1;
      hold_q  <= '0;
      pull_q  <= 1'b1;
      bll_q   <= '0;
      cfgv_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      csn_q   <= 1'b1;
      mosi_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      wcnt_q  <= wcnt_d;
      sr_q    <= sr_d;
      tx_q    <= tx_d;
      prev_q  <= prev_d;
      hold_q  <= hold_d;
      pull_q  <= pull_d;
      bll_q   <= bll_d;
      cfgv_q  <= cfgv_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      done_q  <= done_d;
      csn_q   <= csn_d;
      mosi_q  <= mosi_d;
    end
  end

  for (genvar g = 0; g < CFG_WORDS; g++) begin : g_cfg
    always_ff @(posedge clk or negedge seq_rst_n) begin
      if (!seq_rst_n)                             cfg_q[32*g +: 32] <= '0;
      else if (cfg_wr && wcnt_q == WCNT_W'(g)) cfg_q[32*g +: 32] <= word_in;
    end
  end

  assign spi_sck    = sck;
  assign spi_cs_n   = csn_q;
  assign spi_mosi   = mosi_q;
  assign pullup_en  = pull_q;
  assign bll        = bll_q;
  assign cfg_data   = cfg_q;
  assign cfg_valid  = cfgv_q;
  assign sram_we    = we_q;
  assign sram_addr  = addr_q;
  assign sram_wdata = wdata_q;
  assign done       = done_q;

  // R9: SRAM writes only happen inside the selected transfer
  a_r9_write_in_transfer: assert property (@(posedge clk) disable iff (!seq_rst_n)
    sram_we |-> !spi_cs_n);
  // R5: the pull-up, once released, stays released
  a_r5_pullup_off_stays: assert property (@(posedge clk) disable iff (!seq_rst_n)
    !pullup_en |=> !pullup_en);
  // R4: the divider is only written while the shift clock is parked low
  a_r4_retune_parked: assert property (@(posedge clk) disable iff (!seq_rst_n)
    div_wr |-> !spi_sck && !spi_cs_n);
  // R11: done is a single cycle and comes with the memory deselected
  a_r11_done_single: assert property (@(posedge clk) disable iff (!seq_rst_n)
    done |=> !done);
  a_r11_done_deselect: assert property (@(posedge clk) disable iff (!seq_rst_n)
    done |-> spi_cs_n && !spi_sck);
endmodule

// File: tb/spi_boot_seq_test.sv
module spi_boot_seq_test;
  localparam int SRAMW = 8;
  localparam int NCFG  = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic rst_n = 1'b0;
  logic spi_miso;
  logic spi_sck, spi_cs_n, spi_mosi, pullup_en, div_valid, cfg_valid, sram_we, done;
  logic [3:0]  div_code;
  logic [15:0] bll;
  logic [32*NCFG-1:0] cfg_data;
  logic [2:0]  sram_addr;
  logic [31:0] sram_wdata;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_boot_seq #(.CFG_WORDS(NCFG), .SRAM_WORDS(SRAMW)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .pullup_en(pullup_en), .div_code(div_code), .div_valid(div_valid),
    .bll(bll), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata), .done(done)
  );

  // memory image and expected values
  logic [7:0]  img [0:255];
  logic [3:0]  exp_code;
  logic [15:0] exp_bll;
  logic [31:0] exp_cfg [0:NCFG-1];
  logic [31:0] exp_boot [0:31];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // SPI memory model
  logic        drv_bit = 1'b1;
  logic        drv_en = 1'b0;
  logic        sck_prev = 1'b0;
  logic        cs_prev = 1'b1;
  int          cmd_cnt = 0;
  int          bitpos = 0;
  int          mosi_err = 0;
  logic [31:0] cmd_cap = '0;

  assign spi_miso = drv_en ? drv_bit : 1'b1;

  always @(spi_sck or spi_cs_n) begin
    if (spi_cs_n !== cs_prev) begin
      if (spi_cs_n === 1'b0) begin
        cmd_cnt = 0; bitpos = 0; mosi_err = 0; cmd_cap = '0;
      end
      drv_en  = 1'b0;
      cs_prev = spi_cs_n;
    end
    if (spi_sck !== sck_prev) begin
      if (spi_cs_n === 1'b0) begin
        if (spi_sck === 1'b1) begin
          if (cmd_cnt < 32) begin
            cmd_cap = {cmd_cap[30:0], spi_mosi};
            cmd_cnt++;
          end else if (spi_mosi !== 1'b0) begin
            mosi_err++;
          end
        end else if (cmd_cnt >= 32) begin
          drv_en  = 1'b1;
          drv_bit = img[(bitpos / 8) % 256][7 - (bitpos % 8)];
          bitpos++;
        end
      end
      sck_prev = spi_sck;
    end
  end

  // output monitor, sampled away from the active edge
  int   gap = 0;
  int   edge_n = 0;
  int   cmd_half = 0;
  int   last_half = 0;
  int   wr_n = 0;
  int   done_n = 0;
  int   pause_seen = 0;
  logic sck_m = 1'b0;
  logic cs_m = 1'b1;
  logic dv_m = 1'b0;

  always @(negedge clk) begin
    gap++;
    if (cs_m && !spi_cs_n) begin
      edge_n = 0;
      gap = 0;
    end
    if (spi_sck !== sck_m) begin
      if (edge_n == 1) cmd_half = gap;
      last_half = gap;
      edge_n++;
      gap = 0;
    end
    if (sram_we) begin
      chk(sram_addr == 3'(wr_n) && sram_wdata == exp_boot[wr_n], "R9 write",
          {29'd0, sram_addr, sram_wdata}, {32'(wr_n), exp_boot[wr_n]});
      wr_n++;
    end
    if (done) done_n++;
    if (div_valid && !dv_m && !spi_sck && !spi_cs_n) pause_seen++;
    sck_m = spi_sck;
    cs_m  = spi_cs_n;
    dv_m  = div_valid;
  end

  function automatic int n_boot(input logic [15:0] l);
    return (l == 16'd0) ? 0 : int'(l) + 1;
  endfunction

  // fills the image: rejected prefix bytes, sync byte, length, config, boot
  task automatic build(input int npre, input bit directed, input logic [3:0] code,
                       input logic [15:0] len);
    int idx;
    logic [7:0] b;
    idx = 0;
    for (int i = 0; i < 256; i++) img[i] = 8'hFF;
    if (directed) begin
      img[0] = 8'h5A;  // upper nibble set
      img[1] = 8'h03;  // zero nibble but preceded by a low bit
      idx = 2;
    end else begin
      for (int i = 0; i < npre; i++) begin
        b = 8'($urandom) | 8'h10;
        if (i == npre - 1) b[0] = 1'b1;
        img[idx] = b;
        idx++;
      end
    end
    img[idx] = {4'h0, code}; idx++;
    exp_bll = len;
    img[idx] = len[15:8]; idx++;
    img[idx] = len[7:0];  idx++;
    for (int k = 0; k < NCFG; k++) begin
      exp_cfg[k] = $urandom;
      for (int j = 3; j >= 0; j--) begin img[idx] = exp_cfg[k][8*j +: 8]; idx++; end
    end
    for (int k = 0; k < n_boot(len); k++) begin
      exp_boot[k] = $urandom;
      for (int j = 3; j >= 0; j--) begin img[idx] = exp_boot[k][8*j +: 8]; idx++; end
    end
  endtask

  task automatic boot(input bit hard, input logic [3:0] stored);
    int waited;
    int nexp;
    @(negedge clk);
    if (hard) por_n = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 0; done_n = 0; pause_seen = 0;
    if (!hard) chk(div_valid == 1'b1 && div_code == stored, "R6 kept through soft reset",
                   {div_valid, div_code}, {1'b1, stored});
    chk(spi_cs_n == 1'b1 && pullup_en == 1'b1 && done == 1'b0 && sram_we == 1'b0,
        "R5 R11 reset state", {spi_cs_n, pullup_en, done, sram_we}, 4'b1100);
    por_n = 1'b1;
    rst_n = 1'b1;
    waited = 0;
    while (done_n == 0 && waited < 30000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_n != 0, "R11 done reached", 64'(done_n), 64'd1);
    repeat (20) @(negedge clk);
    chk(cmd_cap == 32'h0300_0000, "R1 command", 64'(cmd_cap), 64'h0300_0000);
    chk(mosi_err == 0, "R1 mosi idle", 64'(mosi_err), 64'd0);
    if (hard) begin
      chk(cmd_half == 16, "R2 default rate", 64'(cmd_half), 64'd16);
      chk(pause_seen == 1, "R4 parked retune", 64'(pause_seen), 64'd1);
      chk(div_code == exp_code && div_valid, "R4 stored code", {div_valid, div_code}, {1'b1, exp_code});
    end else begin
      chk(cmd_half == int'(stored) + 1, "R6 stored rate", 64'(cmd_half), 64'(int'(stored) + 1));
      chk(pause_seen == 0 && div_code == stored, "R6 no retune", {pause_seen[3:0], div_code}, {4'd0, stored});
    end
    chk(last_half == int'(div_code) + 1, "R4 new rate", 64'(last_half), 64'(int'(div_code) + 1));
    chk(pullup_en == 1'b0, "R5 pull-up released", 64'(pullup_en), 64'd0);
    chk(bll == exp_bll, "R3 R7 length after sync", 64'(bll), 64'(exp_bll));
    for (int k = 0; k < NCFG; k++)
      chk(cfg_data[32*k +: 32] == exp_cfg[k], "R8 config word", 64'(cfg_data[32*k +: 32]), 64'(exp_cfg[k]));
    chk(cfg_valid == 1'b1, "R8 cfg_valid", 64'(cfg_valid), 64'd1);
    nexp = n_boot(exp_bll);
    if (nexp > SRAMW) nexp = SRAMW;
    chk(wr_n == nexp, "R9 R10 write count", 64'(wr_n), 64'(nexp));
    chk(done_n == 1 && spi_cs_n && !spi_sck, "R11 single done, deselected",
        {done_n[3:0], spi_cs_n, spi_sck}, {4'd1, 1'b1, 1'b0});
  endtask

  initial begin
    logic [3:0] c;
    void'($urandom(32'd20240611));
    // directed: two rejects (nibble, then missing high bit), code 2, four words
    exp_code = 4'd2;
    build(0, 1'b1, 4'd2, 16'd3);
    boot(1'b1, 4'd0);
    // soft reset: stored code reused, code in stream ignored, zero length
    build(0, 1'b0, 4'd9, 16'd0);
    boot(1'b0, 4'd2);
    // fastest divider, length beyond SRAM
    exp_code = 4'd0;
    build(0, 1'b0, 4'd0, 16'd9);
    boot(1'b1, 4'd0);
    // random power-on boots
    for (int r = 0; r < 4; r++) begin
      c = 4'($urandom_range(0, 15));
      exp_code = c;
      build($urandom_range(0, 3), 1'b0, c, 16'($urandom_range(0, 4)));
      boot(1'b1, 4'd0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule